// File: doc/BRIEF.md
# Three-Timer Up/Down Counter Group with Quadrature Decoding

This block holds three 16-bit counters: one core timer and two auxiliary timers. Each timer can count in one of several ways. It can count prescaled system clock ticks, either freely or only while a gate pin is at its active level. It can count edges on its count pin. It can also follow a two-phase incremental position encoder wired to its count and direction pins. The count direction comes from a software bit, which can be combined with the timer's direction pin.

The core timer drives a toggle latch that flips each time the core wraps. An auxiliary timer can instead act as a passive register. As a capture register, it snapshots the core timer on a pin edge. As a reload register, it loads its value into the core timer on a pin edge or on a chosen latch transition. When the two auxiliaries reload on opposite latch transitions, the latch output becomes a free-running PWM with high and low times set independently. Software reaches the six registers through a single write port.

Top module: `tri_timer`

## Requirements
- R1: After reset, all three counts are 0000h, the toggle output is 0 and every control register is 0, so no timer counts.
- R2: Control word fields are: mode [2:0] (0 timer, 1 gated, 2 event counter, 3 incremental, 4 reload register, 5 capture register, 6 and 7 idle), run [3], and prescale select k [8:6]. In timer mode with run set, the count moves by exactly one per 2^(3+k) system clocks. With run clear, the count holds.
- R3: In gated mode the timer counts at the prescaled rate only while its count pin equals the gate level in bit [13]. Otherwise it holds.
- R4: Outside incremental mode the timer counts down when bit [4] XOR (bit [5] AND direction pin) is 1, and up otherwise.
- R5: In event-counter mode, edge select [10:9] chooses which count-pin edges add one step: 01 rising, 10 falling, 11 both, 00 none.
- R6: In incremental mode the count pin is phase A and the direction pin is phase B. A change of A alone steps up when A differs from B after the change. A change of B alone steps up when B equals A after the change. A simultaneous change of both is ignored. Bit [4] reverses the sense.
- R7: Counting up from FFFFh wraps to 0000h, and counting down from 0000h wraps to FFFFh. Every wrap of the core timer flips the toggle output.
- R8: An auxiliary timer in capture mode does not count, whatever its run bit. On a selected edge of its count pin, it copies the core value.
- R9: An auxiliary timer in reload mode does not count. On a selected edge of its count pin, it loads its value into the core timer.
- R10: With bit [11] set, a reload-mode auxiliary also reloads the core in place of the wrap value at a core wrap. It does so when the wrap takes the latch 0→1 (bit [12]=0) or 1→0 (bit [12]=1). With reload values R0 and R1 on opposite transitions and up counting, the latch stays high for (10000h−R0) ticks and low for (10000h−R1) ticks. Auxiliary 0 wins over auxiliary 1 when both reload at once.
- R11: Write addresses are: 0 core count, 1 auxiliary 0 count, 2 auxiliary 1 count, 4/5/6 their control words, 3 and 7 unused. A count write takes effect at the next edge and wins over any step, reload or capture in that cycle.
- R12: Pin inputs pass through two synchronizer stages and one edge stage. A pin change is first acted on at the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cnt_pin | input | 3 | Count/gate/phase A pins (bit 0 core, 1 aux 0, 2 aux 1) |
| dir_pin | input | 3 | Direction/phase B pins, same order |
| core_cnt | output | 16 | Core timer value |
| aux0_cnt | output | 16 | Auxiliary timer 0 value |
| aux1_cnt | output | 16 | Auxiliary timer 1 value |
| tog_out | output | 1 | Core toggle latch |

## Verification
Several rules are checked on every cycle. The toggle output only flips just after the core sat at FFFFh or 0000h. A core count write always lands. Without reloads the core moves by at most one per cycle. In a prescaled mode it never steps in two consecutive cycles. A reload-mode auxiliary holds its value. Prescale rates, gating polarity, edge selection, quadrature direction and illegal transitions, capture and reload values, and the exact PWM high and low times can only be seen in the bench's directed sweeps.

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int W       = 16,
  parameter int PS_BITS = 3,
  parameter int PS_MIN  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   cnt_pin,
  input  logic [2:0]   dir_pin,
  output logic [W-1:0] core_cnt,
  output logic [W-1:0] aux0_cnt,
  output logic [W-1:0] aux1_cnt,
  output logic         tog_out
);
  localparam int NT    = 3;
  localparam int CW    = 14;
  localparam int PRE_W = PS_MIN + (1 << PS_BITS) - 1;
  localparam logic [2:0] M_TIM = 3'd0, M_GAT = 3'd1, M_CNT = 3'd2,
                         M_INC = 3'd3, M_RLD = 3'd4, M_CAP = 3'd5;

  logic [PRE_W-1:0]       presc;
  logic [NT-1:0][W-1:0]   cnt, nxt;
  logic [NT-1:0][CW-1:0]  ctl;
  logic [NT-1:0]          a1, a2, a3, b1, b2, b3;
  logic [NT-1:0]          step, down, ev, rld;
  logic                   tog, wrap0, core_wr;

  assign core_wr = wr_en && wr_addr == 3'd0;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      logic [PRE_W-1:0] msk;
      logic tick, ach, bch, qup;
      msk   = (PRE_W'(1) << (PS_MIN + int'(ctl[i][8:6]))) - PRE_W'(1);
      tick  = &(presc | ~msk);
      ev[i] = (ctl[i][9] & a2[i] & ~a3[i]) | (ctl[i][10] & ~a2[i] & a3[i]);
      ach   = a2[i] ^ a3[i];
      bch   = b2[i] ^ b3[i];
      qup   = ach ? (a2[i] ^ b2[i]) : ~(a2[i] ^ b2[i]);
      if (ctl[i][2:0] == M_INC) down[i] = ~qup ^ ctl[i][4];
      else                      down[i] = ctl[i][4] ^ (ctl[i][5] & b2[i]);
      case (ctl[i][2:0])
        M_TIM:   step[i] = ctl[i][3] & tick;
        M_GAT:   step[i] = ctl[i][3] & tick & (a2[i] == ctl[i][13]);
        M_CNT:   step[i] = ctl[i][3] & ev[i];
        M_INC:   step[i] = ctl[i][3] & (ach ^ bch);
        default: step[i] = 1'b0;
      endcase
      nxt[i] = down[i] ? cnt[i] - 1'b1 : cnt[i] + 1'b1;
    end
  end

  assign wrap0 = step[0] & ~core_wr & (down[0] ? (cnt[0] == '0) : (&cnt[0]));

  always_comb begin
    rld[0] = 1'b0;
    for (int i = 1; i < NT; i++)
      rld[i] = (ctl[i][2:0] == M_RLD) &
               (ev[i] | (ctl[i][11] & wrap0 & (tog == ctl[i][12])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      cnt   <= '0;
      ctl   <= '0;
      a1 <= '0; a2 <= '0; a3 <= '0;
      b1 <= '0; b2 <= '0; b3 <= '0;
      tog   <= 1'b0;
    end else begin
      presc <= presc + 1'b1;
      a1 <= cnt_pin; a2 <= a1; a3 <= a2;
      b1 <= dir_pin; b2 <= b1; b3 <= b2;
      if (wrap0) tog <= ~tog;
      for (int i = 0; i < NT; i++)
        if (wr_en && wr_addr == 3'(i + 4)) ctl[i] <= wr_data[CW-1:0];
      if (core_wr)      cnt[0] <= wr_data;
      else if (rld[1])  cnt[0] <= cnt[1];
      else if (rld[2])  cnt[0] <= cnt[2];
      else if (step[0]) cnt[0] <= nxt[0];
      for (int i = 1; i < NT; i++) begin
        if (wr_en && wr_addr == 3'(i))                cnt[i] <= wr_data;
        else if (ctl[i][2:0] == M_CAP && ev[i])       cnt[i] <= cnt[0];
        else if (step[i])                             cnt[i] <= nxt[i];
      end
    end
  end

  assign core_cnt = cnt[0];
  assign aux0_cnt = cnt[1];
  assign aux1_cnt = cnt[2];
  assign tog_out  = tog;
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] core_cnt,
  input logic [W-1:0] aux0_cnt,
  input logic [W-1:0] aux1_cnt,
  input logic         tog_out
);
  localparam logic [2:0] RLD = 3'd4;
  logic [2:0] sm0, sm1, sm2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm0 <= '0; sm1 <= '0; sm2 <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd4) sm0 <= wr_data[2:0];
      if (wr_addr == 3'd5) sm1 <= wr_data[2:0];
      if (wr_addr == 3'd6) sm2 <= wr_data[2:0];
    end
  end

  a_r7_toggle_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_out) |-> ($past(core_cnt) == '1 || $past(core_cnt) == '0));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_addr) == 3'd0) |-> core_cnt == $past(wr_data));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(sm1) != RLD && $past(sm2) != RLD) |->
      (core_cnt == $past(core_cnt) || core_cnt == W'($past(core_cnt) + 1'b1)
       || core_cnt == W'($past(core_cnt) - 1'b1)));

  a_r2_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(wr_en, 2) && $past(sm0) <= 3'd1 && $past(sm0, 2) <= 3'd1
     && $past(sm1) != RLD && $past(sm2) != RLD
     && $past(sm1, 2) != RLD && $past(sm2, 2) != RLD) |->
      !(core_cnt != $past(core_cnt) && $past(core_cnt) != $past(core_cnt, 2)));

  a_r9_aux0_reload_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sm1) == RLD && !($past(wr_en) && $past(wr_addr) == 3'd1)) |-> $stable(aux0_cnt));

  a_r9_aux1_reload_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sm2) == RLD && !($past(wr_en) && $past(wr_addr) == 3'd2)) |-> $stable(aux1_cnt));
endmodule

bind tri_timer tri_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .core_cnt(core_cnt), .aux0_cnt(aux0_cnt), .aux1_cnt(aux1_cnt), .tog_out(tog_out)
);

// File: tb/tri_timer_test.sv
`timescale 1ns/1ps
module tri_timer_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, cnt_pin = 0, dir_pin = 0;
  logic [15:0] wr_data = 0, core_cnt, aux0_cnt, aux1_cnt;
  logic tog_out;
  int n_chk = 0, n_fail = 0;

  tri_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                 .cnt_pin(cnt_pin), .dir_pin(dir_pin), .core_cnt(core_cnt), .aux0_cnt(aux0_cnt),
                 .aux1_cnt(aux1_cnt), .tog_out(tog_out));

  always #10 clk = ~clk;

  function automatic logic [15:0] cw(int md, bit run, bit dn, bit xd, int ps, int es,
                                     bit tl, bit tp, bit gp);
    return 16'(md) | (16'(run) << 3) | (16'(dn) << 4) | (16'(xd) << 5) | (16'(ps) << 6)
         | (16'(es) << 9) | (16'(tl) << 11) | (16'(tp) << 12) | (16'(gp) << 13);
  endfunction

  task automatic ceq(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(int idx);
    cnt_pin[idx] = 1; cyc(4);
    cnt_pin[idx] = 0; cyc(4);
  endtask

  task automatic qs(logic a, logic b);
    cnt_pin[0] = a; dir_pin[0] = b; cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    cyc(3); rst_n = 1; cyc(1);
    ceq("R1 core", core_cnt, 0); ceq("R1 aux0", aux0_cnt, 0);
    ceq("R1 aux1", aux1_cnt, 0); ceq("R1 tog", tog_out, 0);
    cyc(40);
    ceq("R1 idle after reset", core_cnt, 0);

    // R2 prescale sweep
    for (int k = 0; k < 8; k++) begin
      wr(0, 0);
      wr(4, cw(0, 1, 0, 0, k, 0, 0, 0, 0));
      cyc(3 << (3 + k));
      ceq($sformatf("R2 prescale k=%0d", k), core_cnt, 3);
      wr(4, 0);
      v = core_cnt; cyc(50);
      ceq("R2 run clear holds", core_cnt, v);
    end

    // R7 underflow and overflow with toggle
    wr(0, 0); wr(4, cw(0, 1, 1, 0, 0, 0, 0, 0, 0)); cyc(16);
    ceq("R7 underflow value", core_cnt, 16'hFFFE); ceq("R7 underflow toggles", tog_out, 1);
    wr(4, 0);
    wr(0, 16'hFFFE); wr(4, cw(0, 1, 0, 0, 0, 0, 0, 0, 0)); cyc(16);
    ceq("R7 overflow value", core_cnt, 0); ceq("R7 overflow toggles", tog_out, 0);
    wr(4, 0);

    // R3 gated, both polarities
    for (int gp = 0; gp < 2; gp++) begin
      wr(0, 0); cnt_pin[0] = 1'(~gp);
      wr(4, cw(1, 1, 0, 0, 0, 0, 0, 0, gp[0])); cyc(4);
      v = core_cnt; cyc(64);
      ceq("R3 gate inactive", core_cnt - v, 0);
      cnt_pin[0] = gp[0]; cyc(4); v = core_cnt; cyc(64);
      ceq("R3 gate active", core_cnt - v, 8);
      wr(4, 0); cnt_pin[0] = 0;
    end

    // R4 external direction
    wr(0, 100); dir_pin[0] = 1; wr(4, cw(0, 1, 0, 1, 0, 0, 0, 0, 0)); cyc(4);
    v = core_cnt; cyc(64);
    ceq("R4 pin reverses to down", v - core_cnt, 8);
    wr(4, cw(0, 1, 1, 1, 0, 0, 0, 0, 0)); cyc(4);
    v = core_cnt; cyc(64);
    ceq("R4 soft down xor pin is up", core_cnt - v, 8);
    wr(4, cw(0, 1, 0, 0, 0, 0, 0, 0, 0)); cyc(4);
    v = core_cnt; cyc(64);
    ceq("R4 pin ignored when disabled", core_cnt - v, 8);
    wr(4, 0); dir_pin[0] = 0;

    // R5 event counting
    for (int es = 0; es < 4; es++) begin
      wr(0, 0); wr(4, cw(2, 1, 0, 0, 0, es, 0, 0, 0));
      repeat (5) pulse(0);
      cyc(4);
      ceq($sformatf("R5 edge select %0d", es), core_cnt, (es == 3) ? 10 : (es == 0 ? 0 : 5));
      wr(4, 0);
    end

    // R6 quadrature
    wr(0, 16'h10); wr(4, cw(3, 1, 0, 0, 0, 0, 0, 0, 0));
    repeat (2) begin qs(1, 0); qs(1, 1); qs(0, 1); qs(0, 0); end
    ceq("R6 forward", core_cnt, 16'h18);
    repeat (3) begin qs(0, 1); qs(1, 1); qs(1, 0); qs(0, 0); end
    ceq("R6 backward", core_cnt, 16'h0C);
    qs(1, 1);
    ceq("R6 double change ignored", core_cnt, 16'h0C);
    qs(0, 1);
    ceq("R6 resume A alone", core_cnt, 16'h0D);
    qs(0, 0);
    ceq("R6 resume B alone", core_cnt, 16'h0E);
    wr(4, cw(3, 1, 1, 0, 0, 0, 0, 0, 0));
    qs(1, 0);
    ceq("R6 sense reversed", core_cnt, 16'h0D);
    wr(4, 0); qs(0, 0);

    // R8 capture
    wr(0, 16'h1234); wr(1, 16'h0055);
    wr(5, cw(5, 1, 0, 0, 0, 1, 0, 0, 0)); cyc(40);
    ceq("R8 capture mode does not count", aux0_cnt, 16'h0055);
    pulse(1);
    ceq("R8 captured core", aux0_cnt, 16'h1234);
    ceq("R8 core unaffected", core_cnt, 16'h1234);

    // R9 external reload
    wr(2, 16'hABCD); wr(6, cw(4, 1, 0, 0, 0, 1, 0, 0, 0)); cyc(40);
    ceq("R9 reload mode does not count", aux1_cnt, 16'hABCD);
    pulse(2);
    ceq("R9 core reloaded", core_cnt, 16'hABCD);
    wr(5, 0); wr(6, 0);

    // R10 PWM from toggle-latch reloads
    wr(1, 16'hFFF0); wr(2, 16'hFFE0);
    wr(5, cw(4, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(6, cw(4, 0, 0, 0, 0, 0, 1, 1, 0));
    wr(0, 16'hFFF0); wr(4, cw(0, 1, 0, 0, 0, 0, 0, 0, 0));
    begin
      logic lvl; int w;
      lvl = tog_out; w = 0;
      while (tog_out == lvl && w < 3000) begin @(negedge clk); w++; end
      for (int s = 0; s < 2; s++) begin
        lvl = tog_out; w = 0;
        while (tog_out == lvl && w < 3000) begin @(negedge clk); w++; end
        ceq(lvl ? "R10 high time" : "R10 low time", w, lvl ? 128 : 256);
      end
    end
    ceq("R10 aux0 kept", aux0_cnt, 16'hFFF0); ceq("R10 aux1 kept", aux1_cnt, 16'hFFE0);
    wr(4, 0); wr(5, 0); wr(6, 0);

    // R11 write priority and addressing
    wr(5, cw(0, 1, 0, 0, 0, 0, 0, 0, 0)); wr(1, 0); cyc(32);
    ceq("R11 aux0 counts as timer", aux0_cnt, 4);
    wr(5, 0);
    wr(4, cw(0, 1, 0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 8; i++) begin
      wr(0, 16'h2000 + 16'(i));
      ceq("R11 write wins over step", core_cnt, 16'h2000 + i);
    end
    wr(4, 0); wr(0, 16'h0AAA); wr(1, 16'h0BBB); wr(2, 16'h0CCC);
    wr(3, 16'h7777); wr(7, 16'h7777); cyc(20);
    ceq("R11 unused addr core", core_cnt, 16'h0AAA);
    ceq("R11 unused addr aux0", aux0_cnt, 16'h0BBB);
    ceq("R11 unused addr aux1", aux1_cnt, 16'h0CCC);

    // R12 latency: pin change acted on at third edge
    wr(0, 0); wr(4, cw(2, 1, 0, 0, 0, 1, 0, 0, 0));
    cnt_pin[0] = 1; cyc(2);
    ceq("R12 not yet after two edges", core_cnt, 0);
    cyc(1);
    ceq("R12 counted at third edge", core_cnt, 1);
    cnt_pin[0] = 0; cyc(4); wr(4, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule